// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block supplies the address for a synchronous burst SRAM. On any rising clock edge where either of its two address strobes is high, it captures the external address and starts a four-beat burst at beat zero. On later cycles the two low address bits come from an internal beat counter. That counter moves forward only on edges where the advance input is high. The upper address bits stay at the captured value for the whole burst.

A static order input chooses how the low bits are built from the starting offset and the beat index:

- **Linear order** adds the beat index to the start, modulo four.
- **Interleaved order** XORs the beat index with the start.

A flag marks the fourth beat. Advancing past the fourth beat wraps the burst back to its starting offset.

A strobe may be given on every cycle. The block then acts as a plain registered address path with no lost cycles, so the burst function is optional. The address, strobes and advance are plain control pins with no handshake. The address and flag come directly from registers through a small combinational map, so each one changes in the cycle that follows the edge that caused it.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held, and after it is released with no strobe yet given, `addr_out` is 0 and `last_beat` is 0.
- R2: A rising edge with `strobe_a` high, `strobe_b` high, or both high captures `addr_in`. After that edge, `addr_out` equals the captured address and the beat index is 0.
- R3: With no strobe, an edge with `advance` high increments the beat index by one. An edge with `advance` low leaves `addr_out` and `last_beat` unchanged.
- R4: With `order_sel` = 0 (linear), the low two bits of `addr_out` on beat n are (start + n) mod 4, where start is the low two bits of the captured address.
- R5: With `order_sel` = 1 (interleaved), the low two bits of `addr_out` on beat n are start XOR n.
- R6: Bits above bit 1 of `addr_out` never change without a strobe. Advancing from beat 3 returns to beat 0, which is the starting offset.
- R7: When a strobe and `advance` are high on the same edge, the strobe wins. The new address is captured at beat 0.
- R8: `last_beat` is 1 exactly when the beat index is 3.
- R9: Strobes on consecutive edges each load their own address with no penalty cycle. Every load is visible in the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| addr_in | input | ADDR_W | External start address |
| strobe_a | input | 1 | First address strobe, loads `addr_in` |
| strobe_b | input | 1 | Second address strobe, loads `addr_in` |
| advance | input | 1 | Step to the next beat of the burst |
| order_sel | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| addr_out | output | ADDR_W | Current burst address |
| last_beat | output | 1 | High on the fourth beat of the burst |

## Verification
The bench runs each of the four starting offsets through a full burst and a wrap in both orders. Offsets 1 and 3 show linear and interleaved order apart, because at those offsets an add differs from an XOR.

Runs of advance interrupted by idle cycles separate stepping from holding. A strobe coinciding with advance shows whether loading has priority.

Back-to-back strobes on alternating pins, then a long random mix of strobes, advances and mode changes, are compared on every clock against a behavioural reference. This shows that either strobe loads and that upper bits change only on a load.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_addr_capture.sv
module burst_addr_capture #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_a,
  input  logic              strobe_b,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              load,
  output logic [ADDR_W-1:0] base
);
  assign load = strobe_a | strobe_b;

  always_ff @(posedge clk) begin
    if (!rst_n) base <= '0;
    else if (load) base <= addr_in;
  end

  // R2: a strobe captures the external address
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_a || strobe_b) |=> base == $past(addr_in));
  // R6: without a strobe the captured address holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_a || strobe_b) |=> $stable(base));
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat,
  output logic              last
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) beat <= '0;
    else if (load) beat <= '0;
    else if (step) beat <= beat + 1'b1;
  end

  assign last = (beat == LAST_BEAT);

  // R7: a load restarts at beat zero even with step high
  p_load_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> beat == '0);
  // R3: a step without a load moves one beat (wrapping)
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> beat == $past(beat) + 1'b1);
  // R3: no step, no load holds the beat
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(beat));
  // R8: the step before the final beat raises last
  p_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && beat == LAST_BEAT - 1'b1) |=> last);
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] offset
);
  logic [BEAT_W-1:0] lin_off;
  logic [BEAT_W-1:0] ilv_off;

  assign lin_off = start + beat;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
    assign ilv_off[i] = start[i] ^ beat[i];
  end

  always_comb begin
    unique case (order)
      ORDER_INTERLEAVED: offset = ilv_off;
      default:           offset = lin_off;
    endcase
  end

  // R5: interleaved beat zero sits on the start offset
  a_ilv_zero_r5: assert final ((beat != '0) || (ilv_off == start));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_a,
  input  logic              strobe_b,
  input  logic              advance,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic              last_beat
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] offset;
  burst_order_e      order;

  assign order = burst_order_e'(order_sel);

  burst_addr_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .addr_in(addr_in), .load(load), .base(base)
  );

  burst_beat_counter #(.BEAT_W(BEAT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .load(load), .step(advance),
    .beat(beat), .last(last_beat)
  );

  burst_offset_map #(.BEAT_W(BEAT_W)) u_map (
    .start(base[BEAT_W-1:0]), .beat(beat), .order(order), .offset(offset)
  );

  assign addr_out = {base[ADDR_W-1:BEAT_W], offset};

  // R2: the address after a strobe is exactly the captured input
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_a || strobe_b) |=> addr_out == $past(addr_in));
  // R6: the upper bits do not move without a strobe
  p_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_a || strobe_b) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));
  // R4: in linear order an advance adds one to the low bits
  p_linear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_a && !strobe_b && advance && !order_sel) |=>
      (order_sel || addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + 1'b1));
  // R8: the flag drops whenever a new burst is loaded
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_a || strobe_b) |=> !last_beat);

  if (UP_W < 1) begin : g_bad_width
    a_width: assert final (1'b0);
  end
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          strobe_a = 1'b0, strobe_b = 1'b0, advance = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] addr_out;
  logic          last_beat;

  int checks = 0, fails = 0;
  int m_base = 0, m_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) i_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_a(strobe_a),
    .strobe_b(strobe_b), .advance(advance), .order_sel(order_sel),
    .addr_out(addr_out), .last_beat(last_beat)
  );

  function automatic int exp_addr();
    int lo;
    lo = order_sel ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) & 3);
    return (m_base & ~3) | lo;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input int a, input bit sa, input bit sb,
                      input bit adv, input bit mode);
    @(negedge clk);
    addr_in = a[AW-1:0]; strobe_a = sa; strobe_b = sb; advance = adv; order_sel = mode;
    @(posedge clk);
    if (sa || sb) begin m_base = a & ((1 << AW) - 1); m_cnt = 0; end
    else if (adv) m_cnt = (m_cnt + 1) & 3;
    #5;
    check(req, int'(addr_out), exp_addr());
    check({req, "_last R8"}, int'(last_beat), (m_cnt == 3) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset addr", int'(addr_out), 0);
    check("R1 reset last", int'(last_beat), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    check("R1 after release", int'(addr_out), 0);

    // linear burst from offset 2 via strobe_a, wrap, then holds
    step("R2 load a", 'h2A5A6, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R4 linear R6", 0, 0, 0, 1, 0);
    step("R3 hold", 'h3FFFF, 0, 0, 0, 0);
    step("R3 hold", 'h00001, 0, 0, 0, 0);
    step("R3 step", 0, 0, 0, 1, 0);

    // interleaved from offset 1 via strobe_b
    step("R2 load b", 'h15551, 0, 1, 0, 1);
    for (int i = 0; i < 5; i++) step("R5 interleave R6", 0, 0, 0, 1, 1);

    // every offset, both orders, with wrap
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        step("R2 load", 'h0ABC0 | s, (s & 1) == 0, (s & 1) == 1, 0, m[0]);
        for (int i = 0; i < 4; i++) step(m ? "R5 offset" : "R4 offset", 0, 0, 0, 1, m[0]);
      end

    // strobe together with advance
    step("R2 load", 'h01233, 1, 0, 0, 0);
    step("R3 step", 0, 0, 0, 1, 0);
    step("R7 strobe beats advance", 'h2FFF2, 1, 0, 1, 0);
    step("R7 strobe beats advance", 'h10001, 0, 1, 1, 1);
    step("R7 both strobes", 'h0F0F3, 1, 1, 1, 1);

    // back-to-back loads
    for (int i = 0; i < 8; i++)
      step("R9 back to back", 'h11111 * (i + 1), i % 2 == 0, i % 2 == 1, 0, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      step("R6 random", $urandom, r[1:0] == 0, r[3:2] == 0, r[4], (i / 50) % 2 == 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule